// File: doc/BRIEF.md
# Terminal-side ISDN layer-1 activation controller

This block keeps track of where a terminal's S-bus layer 1 stands in its activation procedure. The line transceiver reports the line condition as a 4-bit indication code, qualified by a one-cycle strobe. Layer 2 can ask for activation with a one-cycle request strobe. In response the block sends 4-bit commands back to the transceiver, each marked by a one-cycle valid strobe. It also raises one-cycle activate and deactivate indication pulses toward layer 2.

The controller models the terminal states F3 to F8, plus a reset state, and F3 is split into three variants. A one-shot supervision timer (T3) limits how long an activation attempt may run. Its length is counted in clock cycles. All outputs are registered: the response to an input seen in cycle k appears right after the clock edge that ends cycle k.

Top module: `te_l1_act`

## Requirements
- R1: Reset and output timing. During reset and after reset, the block is in the reset state and holds cmd_vld, act_ind and deact_ind low. The state output uses this encoding: reset=0, F3 power-down=1, F3 power-up=2, F3 pending-deactivate=3, F4=4, F5=5, F6=6, F7=7, F8=8. Every response is registered and appears at the first clock edge after the input cycle. Every output strobe lasts one cycle.
- R2: Reset (0001) or error (0110) indication outside F7. The block moves to the reset state and sends the deactivate command 0xF. It raises no indication toward layer 2.
- R3: Reset (0001) or error (0110) indication in F7. The block does everything R2 describes and also raises deact_ind.
- R4: Activation indication (1100) in any state other than F7. The block moves to F7, sends the activate command 0x8, raises act_ind and stops the T3 timer. In F7 the same code is ignored.
- R5: act_req in F3 power-down. The block sends command 0x8 and starts the T3 timer, reloading it if it is already running. The state does not change. act_req has no effect in any other state.
- R6: Deactivate confirm (1111) moves the block to F3 power-down from reset, F3 pending-deactivate, F4, F5, F6 and F8.
- R7: Forward transitions.
  - 0111 takes F3 power-down to F4.
  - 0100 takes F3 power-down, F3 pending-deactivate and F4 to F5.
  - 0100 takes F6 to F8.
  - 1000 takes reset, F3 power-down, F3 pending-deactivate, F5 and F8 to F6.
- R8: Deactivation from F5, F6 and F8. Code 0000 in F5 or F8, and code 0101 in F6, move the block to F3 pending-deactivate and send command 0xF.
- R9: Leaving F7 with a deactivate indication. Each of these moves raises deact_ind:
  - 1000 moves to F6.
  - 0100 moves to F8.
  - 0000 moves to F3 pending-deactivate and also sends command 0xF.
- R10: T3 expiry. If the timer runs out T3_CYCLES cycles after the command that started it, and the block is in F3 power-down, F4, F5, F6 or F8, the block sends 0xF and raises deact_ind without changing state. The timer fires once and does not restart by itself.
- R11: Any indication code that has no transition in the current state is ignored. The state does not change and no output strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ind_vld | input | 1 | Strobe qualifying ind_code |
| ind_code | input | 4 | Indication code from the transceiver |
| act_req | input | 1 | Activation request strobe from layer 2 |
| cmd_vld | output | 1 | Strobe qualifying cmd_code |
| cmd_code | output | 4 | Command code to the transceiver |
| act_ind | output | 1 | Activate indication pulse to layer 2 |
| deact_ind | output | 1 | Deactivate indication pulse to layer 2 |
| state_o | output | 4 | Current activation state |

## Verification
The bench walks every listed transition and checks the state and the strobes that each move must produce. A design that forgets the F7-only deactivate indication would let layer 2 think the link is still up after a reset or error. Timer expiry is measured to the exact cycle, both after a restart and after a reload, so an off-by-one counter or a timer that is not reloaded shows up as a shifted or missing deactivate command. The bench also checks that an activation indication stops a running timer; a design that missed this would tear down a live link. Finally, it feeds codes that have no transition and an act_req outside F3 power-down, and checks that nothing happens; a design that drifted state or emitted spurious commands would be caught here.

// File: rtl/te_l1_pkg.sv
package te_l1_pkg;

  typedef enum logic [3:0] {
    ST_RST    = 4'd0,
    ST_F3PD   = 4'd1,
    ST_F3PU   = 4'd2,
    ST_F3PEND = 4'd3,
    ST_F4     = 4'd4,
    ST_F5     = 4'd5,
    ST_F6     = 4'd6,
    ST_F7     = 4'd7,
    ST_F8     = 4'd8
  } l1_state_e;

  typedef enum logic [3:0] {
    EV_NONE, EV_RES, EV_DR, EV_RSY, EV_DR6, EV_PU, EV_AR, EV_AI8, EV_DC
  } l1_event_e;

  localparam logic [3:0] IND_DR  = 4'h0;
  localparam logic [3:0] IND_RES = 4'h1;
  localparam logic [3:0] IND_RSY = 4'h4;
  localparam logic [3:0] IND_DR6 = 4'h5;
  localparam logic [3:0] IND_EI  = 4'h6;
  localparam logic [3:0] IND_PU  = 4'h7;
  localparam logic [3:0] IND_AR  = 4'h8;
  localparam logic [3:0] IND_AI8 = 4'hC;
  localparam logic [3:0] IND_DC  = 4'hF;

  localparam logic [3:0] CMD_AR8 = 4'h8;
  localparam logic [3:0] CMD_DI  = 4'hF;

endpackage

// File: rtl/te_l1_ind_decode.sv
module te_l1_ind_decode
  import te_l1_pkg::*;
(
  input  logic       vld,
  input  logic [3:0] code,
  output l1_event_e  ev
);

  always_comb begin
    ev = EV_NONE;
    if (vld) begin
      case (code)
        IND_RES, IND_EI: ev = EV_RES;
        IND_DR:          ev = EV_DR;
        IND_RSY:         ev = EV_RSY;
        IND_DR6:         ev = EV_DR6;
        IND_PU:          ev = EV_PU;
        IND_AR:          ev = EV_AR;
        IND_AI8:         ev = EV_AI8;
        IND_DC:          ev = EV_DC;
        default:         ev = EV_NONE;
      endcase
    end
  end

endmodule

// File: rtl/te_l1_t3_timer.sv
module te_l1_t3_timer #(
  parameter int T3_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic expire
);

  localparam int CW = $clog2(T3_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  assign expire = run_q && (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = CW'(T3_CYCLES);
      run_d = 1'b1;
    end else if (stop || expire) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/te_l1_next.sv
module te_l1_next
  import te_l1_pkg::*;
(
  input  l1_state_e  cur,
  input  l1_event_e  ev,
  input  logic       t3_exp,
  input  logic       act_req,
  output l1_state_e  nxt,
  output logic       cmd_go,
  output logic [3:0] cmd,
  output logic       act_go,
  output logic       deact_go,
  output logic       t3_start,
  output logic       t3_stop
);

  always_comb begin
    nxt      = cur;
    cmd_go   = 1'b0;
    cmd      = CMD_DI;
    act_go   = 1'b0;
    deact_go = 1'b0;
    t3_start = 1'b0;
    t3_stop  = 1'b0;
    if (ev != EV_NONE) begin
      case (ev)
        EV_RES: begin
          nxt      = ST_RST;
          cmd_go   = 1'b1;
          deact_go = (cur == ST_F7);
        end
        EV_AI8: if (cur != ST_F7) begin
          nxt     = ST_F7;
          cmd_go  = 1'b1;
          cmd     = CMD_AR8;
          act_go  = 1'b1;
          t3_stop = 1'b1;
        end
        EV_DC: if (cur inside {ST_RST, ST_F3PEND, ST_F4, ST_F5, ST_F6, ST_F8})
          nxt = ST_F3PD;
        EV_PU: if (cur == ST_F3PD) nxt = ST_F4;
        EV_RSY: begin
          if (cur inside {ST_F3PD, ST_F3PEND, ST_F4}) nxt = ST_F5;
          else if (cur == ST_F6) nxt = ST_F8;
          else if (cur == ST_F7) begin
            nxt      = ST_F8;
            deact_go = 1'b1;
          end
        end
        EV_AR: begin
          if (cur inside {ST_RST, ST_F3PD, ST_F3PEND, ST_F5, ST_F8}) nxt = ST_F6;
          else if (cur == ST_F7) begin
            nxt      = ST_F6;
            deact_go = 1'b1;
          end
        end
        EV_DR: if (cur inside {ST_F5, ST_F7, ST_F8}) begin
          nxt      = ST_F3PEND;
          cmd_go   = 1'b1;
          deact_go = (cur == ST_F7);
        end
        EV_DR6: if (cur == ST_F6) begin
          nxt    = ST_F3PEND;
          cmd_go = 1'b1;
        end
        default: ;
      endcase
    end else if (t3_exp) begin
      if (cur inside {ST_F3PD, ST_F4, ST_F5, ST_F6, ST_F8}) begin
        cmd_go   = 1'b1;
        deact_go = 1'b1;
      end
    end else if (act_req && (cur == ST_F3PD)) begin
      cmd_go   = 1'b1;
      cmd      = CMD_AR8;
      t3_start = 1'b1;
    end
  end

endmodule

// File: rtl/te_l1_act.sv
module te_l1_act
  import te_l1_pkg::*;
#(
  parameter int T3_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ind_vld,
  input  logic [3:0] ind_code,
  input  logic       act_req,
  output logic       cmd_vld,
  output logic [3:0] cmd_code,
  output logic       act_ind,
  output logic       deact_ind,
  output logic [3:0] state_o
);

  l1_state_e  cur_q, nxt;
  l1_event_e  ev;
  logic       t3_exp, t3_start, t3_stop;
  logic       cmd_go, act_go, deact_go;
  logic [3:0] cmd_nxt;

  te_l1_ind_decode u_dec (
    .vld  (ind_vld),
    .code (ind_code),
    .ev   (ev)
  );

  te_l1_t3_timer #(.T3_CYCLES(T3_CYCLES)) u_t3 (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (t3_start),
    .stop   (t3_stop),
    .expire (t3_exp)
  );

  te_l1_next u_nxt (
    .cur      (cur_q),
    .ev       (ev),
    .t3_exp   (t3_exp),
    .act_req  (act_req),
    .nxt      (nxt),
    .cmd_go   (cmd_go),
    .cmd      (cmd_nxt),
    .act_go   (act_go),
    .deact_go (deact_go),
    .t3_start (t3_start),
    .t3_stop  (t3_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= ST_RST;
      cmd_vld   <= 1'b0;
      cmd_code  <= 4'h0;
      act_ind   <= 1'b0;
      deact_ind <= 1'b0;
    end else begin
      cur_q     <= nxt;
      cmd_vld   <= cmd_go;
      act_ind   <= act_go;
      deact_ind <= deact_go;
      if (cmd_go) cmd_code <= cmd_nxt;
    end
  end

  assign state_o = cur_q;

endmodule

// File: rtl/te_l1_act_chk.sv
module te_l1_act_chk
  import te_l1_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ind_vld,
  input logic       cmd_vld,
  input logic [3:0] cmd_code,
  input logic       act_ind,
  input logic       deact_ind,
  input logic [3:0] state_o
);

  // R4
  act_ind_in_f7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_ind |-> (state_o == 4'(ST_F7)) && cmd_vld && (cmd_code == CMD_AR8));

  // R9
  leave_f7_deact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 4'(ST_F7) && state_o != 4'(ST_F7)) |-> deact_ind);

  // R11
  state_needs_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_vld |=> $stable(state_o));

  // R1
  ind_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_ind && deact_ind));

  // R5
  ar8_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_code == CMD_AR8) |-> (state_o == 4'(ST_F7) || state_o == 4'(ST_F3PD)));

  // R1
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 4'(ST_F8));

endmodule

bind te_l1_act te_l1_act_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ind_vld   (ind_vld),
  .cmd_vld   (cmd_vld),
  .cmd_code  (cmd_code),
  .act_ind   (act_ind),
  .deact_ind (deact_ind),
  .state_o   (state_o)
);

// File: tb/sim_te_l1_act.sv
module sim_te_l1_act;

  localparam int T3 = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ind_vld;
  logic [3:0] ind_code;
  logic       act_req;
  logic       cmd_vld;
  logic [3:0] cmd_code;
  logic       act_ind;
  logic       deact_ind;
  logic [3:0] state_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  te_l1_act #(.T3_CYCLES(T3)) u0 (
    .clk(clk), .rst_n(rst_n), .ind_vld(ind_vld), .ind_code(ind_code),
    .act_req(act_req), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .act_ind(act_ind), .deact_ind(deact_ind), .state_o(state_o)
  );

  function automatic logic [31:0] obs();
    return {21'd0, state_o, cmd_vld, (cmd_vld ? cmd_code : 4'h0), act_ind, deact_ind};
  endfunction

  function automatic logic [31:0] exp_v(input logic [3:0] st, input logic cv,
                                        input logic [3:0] cc, input logic a, input logic d);
    return {21'd0, st, cv, cc, a, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // drive an indication at a falling edge, sample at the next falling edge
  task automatic ind(input string req, input logic [3:0] code, input logic [3:0] st,
                     input logic cv, input logic [3:0] cc, input logic a, input logic d);
    ind_vld = 1'b1; ind_code = code;
    @(negedge clk);
    ind_vld = 1'b0;
    chk(req, obs(), exp_v(st, cv, cc, a, d));
  endtask

  task automatic areq(input string req, input logic [3:0] st, input logic cv);
    act_req = 1'b1;
    @(negedge clk);
    act_req = 1'b0;
    chk(req, obs(), exp_v(st, cv, cv ? 4'h8 : 4'h0, 1'b0, 1'b0));
  endtask

  task automatic wait_cmd(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (cmd_vld) begin n = i; break; end
    end
  endtask

  task automatic t_reset();
    ind_vld = 1'b0; ind_code = 4'h0; act_req = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", obs(), exp_v(4'd0, 0, 4'h0, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", obs(), exp_v(4'd0, 0, 4'h0, 0, 0));
  endtask

  task automatic t_walk();
    ind("R2 reset code", 4'h1, 4'd0, 1, 4'hF, 0, 0);
    ind("R2 error code", 4'h6, 4'd0, 1, 4'hF, 0, 0);
    ind("R6 rst->F3PD", 4'hF, 4'd1, 0, 4'h0, 0, 0);
    ind("R7 F3PD->F4", 4'h7, 4'd4, 0, 4'h0, 0, 0);
    ind("R7 F4->F5", 4'h4, 4'd5, 0, 4'h0, 0, 0);
    ind("R8 F5 DR", 4'h0, 4'd3, 1, 4'hF, 0, 0);
    ind("R7 pend->F5", 4'h4, 4'd5, 0, 4'h0, 0, 0);
    ind("R6 F5->F3PD", 4'hF, 4'd1, 0, 4'h0, 0, 0);
    ind("R7 F3PD->F6", 4'h8, 4'd6, 0, 4'h0, 0, 0);
    ind("R8 F6 DR6", 4'h5, 4'd3, 1, 4'hF, 0, 0);
    ind("R7 pend->F6", 4'h8, 4'd6, 0, 4'h0, 0, 0);
    ind("R7 F6->F8", 4'h4, 4'd8, 0, 4'h0, 0, 0);
    ind("R8 F8 DR", 4'h0, 4'd3, 1, 4'hF, 0, 0);
    ind("R6 pend->F3PD", 4'hF, 4'd1, 0, 4'h0, 0, 0);
    ind("R7 F3PD->F5", 4'h4, 4'd5, 0, 4'h0, 0, 0);
    ind("R7 F5->F6", 4'h8, 4'd6, 0, 4'h0, 0, 0);
    ind("R6 F6->F3PD", 4'hF, 4'd1, 0, 4'h0, 0, 0);
    ind("R2 F3PD reset", 4'h1, 4'd0, 1, 4'hF, 0, 0);
    ind("R7 rst->F6", 4'h8, 4'd6, 0, 4'h0, 0, 0);
    ind("R2 F6 error", 4'h6, 4'd0, 1, 4'hF, 0, 0);
  endtask

  task automatic t_f7();
    ind("R4 rst->F7", 4'hC, 4'd7, 1, 4'h8, 1, 0);
    ind("R4 AI8 in F7 ignored", 4'hC, 4'd7, 0, 4'h0, 0, 0);
    ind("R9 F7 resync", 4'h4, 4'd8, 0, 4'h0, 0, 1);
    ind("R7 F8->F6", 4'h8, 4'd6, 0, 4'h0, 0, 0);
    ind("R4 F6->F7", 4'hC, 4'd7, 1, 4'h8, 1, 0);
    ind("R9 F7 AR", 4'h8, 4'd6, 0, 4'h0, 0, 1);
    ind("R6 F6->F3PD", 4'hF, 4'd1, 0, 4'h0, 0, 0);
    ind("R4 F3PD->F7", 4'hC, 4'd7, 1, 4'h8, 1, 0);
    ind("R9 F7 DR", 4'h0, 4'd3, 1, 4'hF, 0, 1);
    ind("R4 pend->F7", 4'hC, 4'd7, 1, 4'h8, 1, 0);
    ind("R3 F7 error", 4'h6, 4'd0, 1, 4'hF, 0, 1);
    ind("R4 rst->F7 again", 4'hC, 4'd7, 1, 4'h8, 1, 0);
    ind("R3 F7 reset", 4'h1, 4'd0, 1, 4'hF, 0, 1);
  endtask

  task automatic t_timer();
    int n;
    ind("R6 to F3PD", 4'hF, 4'd1, 0, 4'h0, 0, 0);
    areq("R5 act_req F3PD", 4'd1, 1);
    wait_cmd(T3 + 5, n);
    chk("R10 expiry cycle", 32'(n), 32'(T3));
    chk("R10 expiry outputs", obs(), exp_v(4'd1, 1, 4'hF, 0, 1));
    wait_cmd(2 * T3, n);
    chk("R10 one-shot", 32'(n), 32'd0);
    areq("R5 first start", 4'd1, 1);
    repeat (10) @(negedge clk);
    areq("R5 reload", 4'd1, 1);
    wait_cmd(T3 + 5, n);
    chk("R5 reload timing", 32'(n), 32'(T3));
    areq("R5 start before F4", 4'd1, 1);
    ind("R7 F3PD->F4 timed", 4'h7, 4'd4, 0, 4'h0, 0, 0);
    areq("R5 act_req ignored in F4", 4'd4, 0);
    wait_cmd(T3 + 5, n);
    chk("R10 expiry in F4 cycle", 32'(n), 32'(T3 - 2));
    chk("R10 expiry in F4 outputs", obs(), exp_v(4'd4, 1, 4'hF, 0, 1));
  endtask

  task automatic t_stop();
    int n;
    ind("R6 F4->F3PD", 4'hF, 4'd1, 0, 4'h0, 0, 0);
    areq("R5 start", 4'd1, 1);
    repeat (3) @(negedge clk);
    ind("R4 AI8 stops timer", 4'hC, 4'd7, 1, 4'h8, 1, 0);
    wait_cmd(2 * T3, n);
    chk("R4 timer stopped", 32'(n), 32'd0);
  endtask

  task automatic t_ignore();
    ind("R9 F7 DR", 4'h0, 4'd3, 1, 4'hF, 0, 1);
    ind("R6 to F3PD", 4'hF, 4'd1, 0, 4'h0, 0, 0);
    ind("R11 code 2", 4'h2, 4'd1, 0, 4'h0, 0, 0);
    ind("R11 code 9", 4'h9, 4'd1, 0, 4'h0, 0, 0);
    ind("R11 DR in F3PD", 4'h0, 4'd1, 0, 4'h0, 0, 0);
    ind("R11 DR6 in F3PD", 4'h5, 4'd1, 0, 4'h0, 0, 0);
    ind("R11 DC in F3PD", 4'hF, 4'd1, 0, 4'h0, 0, 0);
    ind("R4 to F7", 4'hC, 4'd7, 1, 4'h8, 1, 0);
    ind("R11 PU in F7", 4'h7, 4'd7, 0, 4'h0, 0, 0);
    ind("R11 DC in F7", 4'hF, 4'd7, 0, 4'h0, 0, 0);
    areq("R5 act_req in F7 ignored", 4'd7, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_walk();
    t_f7();
    t_timer();
    t_stop();
    t_ignore();
    finish_run();
  end

endmodule